// File: doc/BRIEF.md
# Byte-Select Asynchronous SRAM Controller

This controller connects a host to an asynchronous SRAM that has a 16-bit data bus and two active-low byte-select pins, one for the upper byte and one for the lower byte. The host presents a read or write request with an address, a 2-bit byte mask and write data. The controller turns the request into chip-select, read-strobe, read/write-line and byte-select waveforms. It returns a one-cycle completion pulse. For reads, the captured data is presented with that pulse.

A configuration bit picks one of two strobe arrangements. In the default arrangement (bit at 0), the byte selects act as the write strobe. The read/write line stays low for the whole write, and the byte selects also pulse during reads. In the alternate arrangement (bit at 1), the byte selects are held for the whole access, and the read/write line acts as the write strobe. A 2-bit hold field then adds data-hold cycles after that strobe is released. A programmable wait count stretches the strobe window of every access. The configuration is sampled when a request is accepted.

Top module: `bsram_ctrl`

## Requirements
- R1: After reset and while idle, mem_cs_n, mem_rd_n, mem_rdwr_n and both mem_bs_n bits are 1, mem_dq_oe is 0, req_ready is 1 and rsp_done is 0.
- R2: A request is accepted on a rising edge where req_valid and req_ready are both 1. In the cycles that follow, mem_cs_n is 0 for exactly 2+W+H cycles, where W is cfg_wait and H is cfg_hold (H counts only for alternate-mode writes, otherwise H is 0). Throughout those cycles, mem_addr holds the request address. Cycle 0 is setup, cycles 1..W+1 form the strobe window, and any remaining cycles are hold cycles. rsp_done is 1 for the one cycle right after, and req_ready returns to 1 in that same cycle.
- R3: In a default-mode write (cfg_bsel_mode=0), mem_rdwr_n is 0 in every access cycle. Each selected mem_bs_n bit is 0 only in the strobe window, and mem_rd_n stays 1.
- R4: In a default-mode read, mem_rd_n is 0 and each selected mem_bs_n bit is 0 only in the strobe window. mem_rdwr_n stays 1.
- R5: In an alternate-mode write (cfg_bsel_mode=1), each selected mem_bs_n bit is 0 in every access cycle, including hold cycles. mem_rdwr_n is 0 only in the strobe window and is 1 during the H hold cycles. mem_rd_n stays 1.
- R6: In an alternate-mode read, each selected mem_bs_n bit is 0 in every access cycle, mem_rd_n is 0 only in the strobe window, and mem_rdwr_n stays 1.
- R7: For a write, mem_dq_oe is 1 in every access cycle, including hold cycles, and mem_dq_o carries the request data. mem_dq_oe is 0 at all other times and during any read.
- R8: For a read, rsp_rdata in the rsp_done cycle equals the value on mem_dq_i during the last strobe-window cycle.
- R9: Bit 1 of req_mask selects the upper byte (mem_bs_n[1], data bits 15:8), and bit 0 selects the lower byte (mem_bs_n[0], bits 7:0). An unselected byte-select stays 1 for the whole access, and a mask of 00 still runs the access.
- R10: While an access is in progress, req_ready is 0 and req_valid is ignored. No second access starts until the completion cycle.
- R11: Changing cfg_bsel_mode, cfg_wait or cfg_hold during an access does not change that access.
- R12: cfg_hold has no effect on default-mode accesses or on reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_bsel_mode | input | 1 | 0: byte selects strobe writes; 1: read/write line strobes writes |
| cfg_hold | input | 2 | Data-hold cycles after the write strobe in alternate mode |
| cfg_wait | input | 4 | Wait cycles added to the strobe window |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 write, 0 read |
| req_addr | input | 21 | Halfword address |
| req_mask | input | 2 | Byte mask, bit 1 upper, bit 0 lower |
| req_wdata | input | 16 | Write data |
| req_ready | output | 1 | Controller idle and able to accept |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 16 | Captured read data |
| mem_addr | output | 21 | SRAM address |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_rd_n | output | 1 | Read strobe, active low |
| mem_rdwr_n | output | 1 | Read/write line, low for write |
| mem_bs_n | output | 2 | Byte selects, active low, bit 1 upper |
| mem_dq_o | output | 16 | Data driven to SRAM |
| mem_dq_oe | output | 1 | Data output enable |
| mem_dq_i | input | 16 | Data from SRAM |

## Verification
Stimulus vectors cover both modes in each direction, with wait counts of 0, small and large. Hold values are chosen so that hold cycles appear only for alternate-mode writes. A nonzero hold on default-mode accesses and on reads shows that the field is ignored there. Masks of 11, 10, 01 and 00 show that the upper and lower selects are independent and that unselected lanes stay idle. The read data pin carries the wanted value only in the last strobe cycle, which pins down the capture point. Directed runs hold a request pending during a busy access and flip every configuration input mid-access, to expose premature acceptance or unlatched settings.

// File: rtl/bsram_pkg.sv
package bsram_pkg;
   typedef enum logic [2:0] {
      PH_IDLE,
      PH_SETUP,
      PH_WAIT,
      PH_LAST,
      PH_HOLD
   } phase_e;
endpackage

// File: rtl/bsram_seq.sv
module bsram_seq
   import bsram_pkg::*;
#(
   parameter int ADDR_W = 21,
   parameter int DATA_W = 16,
   parameter int LANES  = 2,
   parameter int WAIT_W = 4,
   parameter int HOLD_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              cfg_mode,
   input  logic [WAIT_W-1:0] cfg_wait,
   input  logic [HOLD_W-1:0] cfg_hold,
   input  logic              in_wr,
   input  logic [ADDR_W-1:0] in_addr,
   input  logic [LANES-1:0]  in_mask,
   input  logic [DATA_W-1:0] in_wdata,
   output phase_e            phase,
   output logic              lat_mode,
   output logic              lat_wr,
   output logic [LANES-1:0]  lat_mask,
   output logic [ADDR_W-1:0] lat_addr,
   output logic [DATA_W-1:0] lat_wdata,
   output logic              done
);
   localparam int CNT_W = (WAIT_W > HOLD_W) ? WAIT_W : HOLD_W;

   logic [CNT_W-1:0]  cnt;
   logic [WAIT_W-1:0] lat_wait;
   logic [HOLD_W-1:0] lat_hold;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase     <= PH_IDLE;
         cnt       <= '0;
         done      <= 1'b0;
         lat_mode  <= 1'b0;
         lat_wr    <= 1'b0;
         lat_mask  <= '0;
         lat_addr  <= '0;
         lat_wdata <= '0;
         lat_wait  <= '0;
         lat_hold  <= '0;
      end else begin
         done <= 1'b0;
         unique case (phase)
            PH_IDLE: if (start) begin
               lat_mode  <= cfg_mode;
               lat_wr    <= in_wr;
               lat_mask  <= in_mask;
               lat_addr  <= in_addr;
               lat_wdata <= in_wdata;
               lat_wait  <= cfg_wait;
               lat_hold  <= cfg_hold;
               phase     <= PH_SETUP;
            end
            PH_SETUP: if (lat_wait == '0) begin
               phase <= PH_LAST;
            end else begin
               phase <= PH_WAIT;
               cnt   <= CNT_W'(lat_wait) - CNT_W'(1);
            end
            PH_WAIT: if (cnt == '0) phase <= PH_LAST;
                     else cnt <= cnt - CNT_W'(1);
            PH_LAST: if (lat_mode && lat_wr && lat_hold != '0) begin
               phase <= PH_HOLD;
               cnt   <= CNT_W'(lat_hold) - CNT_W'(1);
            end else begin
               phase <= PH_IDLE;
               done  <= 1'b1;
            end
            PH_HOLD: if (cnt == '0) begin
               phase <= PH_IDLE;
               done  <= 1'b1;
            end else begin
               cnt <= cnt - CNT_W'(1);
            end
            default: phase <= PH_IDLE;
         endcase
      end
   end

   // R2
   wait_cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_WAIT) |-> (cnt < CNT_W'(lat_wait)));
   // R5
   hold_only_mode1_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_HOLD) |-> (lat_mode && lat_wr && cnt < CNT_W'(lat_hold)));
endmodule

// File: rtl/bsram_strobe.sv
module bsram_strobe
   import bsram_pkg::*;
#(
   parameter int LANES = 2
) (
   input  phase_e           phase,
   input  logic             lat_mode,
   input  logic             lat_wr,
   input  logic [LANES-1:0] lat_mask,
   output logic             cs_n,
   output logic             rd_n,
   output logic             rdwr_n,
   output logic [LANES-1:0] bs_n,
   output logic             dq_oe
);
   logic active, window;

   always_comb begin
      active = (phase != PH_IDLE);
      window = (phase == PH_WAIT) || (phase == PH_LAST);
      cs_n   = !active;
      rd_n   = !(window && !lat_wr);
      dq_oe  = active && lat_wr;
      if (lat_mode) rdwr_n = !(window && lat_wr);
      else          rdwr_n = !(active && lat_wr);
   end

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      always_comb begin
         if (lat_mode) bs_n[g] = !(active && lat_mask[g]);
         else          bs_n[g] = !(window && lat_mask[g]);
      end
   end
endmodule

// File: rtl/bsram_ctrl.sv
module bsram_ctrl
   import bsram_pkg::*;
#(
   parameter int ADDR_W = 21,
   parameter int DATA_W = 16,
   parameter int WAIT_W = 4,
   parameter int HOLD_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_bsel_mode,
   input  logic [HOLD_W-1:0] cfg_hold,
   input  logic [WAIT_W-1:0] cfg_wait,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W/8-1:0] req_mask,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              req_ready,
   output logic              rsp_done,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_cs_n,
   output logic              mem_rd_n,
   output logic              mem_rdwr_n,
   output logic [DATA_W/8-1:0] mem_bs_n,
   output logic [DATA_W-1:0] mem_dq_o,
   output logic              mem_dq_oe,
   input  logic [DATA_W-1:0] mem_dq_i
);
   localparam int LANES = DATA_W / 8;

   if (DATA_W != 16) begin : g_bad_width
      $error("bsram_ctrl: DATA_W must be 16");
   end
   if (WAIT_W < 1 || HOLD_W < 1) begin : g_bad_cnt
      $error("bsram_ctrl: WAIT_W and HOLD_W must be at least 1");
   end

   phase_e            phase;
   logic              lat_mode, lat_wr;
   logic [LANES-1:0]  lat_mask;

   assign req_ready = (phase == PH_IDLE);

   bsram_seq #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANES(LANES),
      .WAIT_W(WAIT_W), .HOLD_W(HOLD_W)
   ) u_seq (
      .clk(clk), .rst_n(rst_n),
      .start(req_valid),
      .cfg_mode(cfg_bsel_mode), .cfg_wait(cfg_wait), .cfg_hold(cfg_hold),
      .in_wr(req_write), .in_addr(req_addr), .in_mask(req_mask),
      .in_wdata(req_wdata),
      .phase(phase), .lat_mode(lat_mode), .lat_wr(lat_wr),
      .lat_mask(lat_mask), .lat_addr(mem_addr), .lat_wdata(mem_dq_o),
      .done(rsp_done)
   );

   bsram_strobe #(.LANES(LANES)) u_strobe (
      .phase(phase), .lat_mode(lat_mode), .lat_wr(lat_wr),
      .lat_mask(lat_mask),
      .cs_n(mem_cs_n), .rd_n(mem_rd_n), .rdwr_n(mem_rdwr_n),
      .bs_n(mem_bs_n), .dq_oe(mem_dq_oe)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                            rsp_rdata <= '0;
      else if (phase == PH_LAST && !lat_wr)  rsp_rdata <= mem_dq_i;
   end

   // R1
   strobe_needs_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!mem_rd_n || !mem_rdwr_n || (mem_bs_n != '1)) |-> !mem_cs_n);
   // R7
   no_drive_on_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_rd_n |-> !mem_dq_oe);
   // R2
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_done |=> !rsp_done);
   // R10
   accept_starts_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> (!mem_cs_n && !req_ready));
   // R9
   mask_honoured_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_bs_n != '1) |-> ((~mem_bs_n & ~lat_mask) == '0));
   // R5
   mode1_we_bs_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lat_mode && !mem_rdwr_n) |-> (mem_bs_n == ~lat_mask));
endmodule

// File: tb/sim_bsram_ctrl.sv
module sim_bsram_ctrl;
   typedef struct packed {
      logic        mode;
      logic        wr;
      logic [1:0]  mask;
      logic [3:0]  wt;
      logic [1:0]  hd;
      logic [15:0] wd;
      logic [15:0] rp;
   } vec_t;

   localparam int NVEC = 9;
   localparam vec_t VEC [NVEC] = '{
      '{1'b0, 1'b1, 2'b11, 4'd0, 2'd3, 16'hA5C3, 16'h0000},
      '{1'b0, 1'b0, 2'b01, 4'd2, 2'd1, 16'h0000, 16'h1234},
      '{1'b1, 1'b1, 2'b10, 4'd1, 2'd2, 16'h5AF0, 16'h0000},
      '{1'b1, 1'b0, 2'b11, 4'd3, 2'd3, 16'h0000, 16'hBEEF},
      '{1'b1, 1'b1, 2'b11, 4'd0, 2'd0, 16'h0F0F, 16'h0000},
      '{1'b0, 1'b1, 2'b10, 4'd5, 2'd0, 16'h7E81, 16'h0000},
      '{1'b1, 1'b1, 2'b01, 4'd2, 2'd3, 16'hC001, 16'h0000},
      '{1'b0, 1'b0, 2'b11, 4'd0, 2'd2, 16'h0000, 16'h8421},
      '{1'b1, 1'b0, 2'b00, 4'd1, 2'd0, 16'h0000, 16'h00FF}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_bsel_mode = 1'b0;
   logic [1:0]  cfg_hold = '0;
   logic [3:0]  cfg_wait = '0;
   logic        req_valid = 1'b0;
   logic        req_write = 1'b0;
   logic [20:0] req_addr = '0;
   logic [1:0]  req_mask = '0;
   logic [15:0] req_wdata = '0;
   logic        req_ready, rsp_done;
   logic [15:0] rsp_rdata;
   logic [20:0] mem_addr;
   logic        mem_cs_n, mem_rd_n, mem_rdwr_n, mem_dq_oe;
   logic [1:0]  mem_bs_n;
   logic [15:0] mem_dq_o;
   logic [15:0] mem_dq_i = '0;

   int n_chk = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   always #10 clk = ~clk;

   bsram_ctrl u0 (
      .clk(clk), .rst_n(rst_n),
      .cfg_bsel_mode(cfg_bsel_mode), .cfg_hold(cfg_hold), .cfg_wait(cfg_wait),
      .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
      .req_mask(req_mask), .req_wdata(req_wdata),
      .req_ready(req_ready), .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
      .mem_addr(mem_addr), .mem_cs_n(mem_cs_n), .mem_rd_n(mem_rd_n),
      .mem_rdwr_n(mem_rdwr_n), .mem_bs_n(mem_bs_n), .mem_dq_o(mem_dq_o),
      .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i)
   );

   task automatic chk(input string tag, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   task automatic run_access(input vec_t v, input logic [20:0] addr,
                             input bit poke, input bit swap_cfg);
      int    hx, n;
      string tag;
      logic  strobe;
      logic [1:0] e_bs;
      hx  = (v.mode && v.wr) ? int'(v.hd) : 0;
      n   = 2 + int'(v.wt) + hx;
      tag = v.mode ? (v.wr ? "R5" : "R6") : (v.wr ? "R3" : "R4");
      if (v.hd != 0 && hx == 0) tag = {tag, "/R12"};
      if (swap_cfg) tag = {tag, "/R11"};
      @(negedge clk);
      cfg_bsel_mode = v.mode; cfg_wait = v.wt; cfg_hold = v.hd;
      req_valid = 1'b1; req_write = v.wr; req_addr = addr;
      req_mask = v.mask; req_wdata = v.wd;
      @(negedge clk);
      req_valid = 1'b0;
      for (int i = 0; i < n; i++) begin
         if (swap_cfg && i == 0) begin
            cfg_bsel_mode = ~v.mode; cfg_wait = 4'd15; cfg_hold = 2'd3;
         end
         if (poke && i == 1) begin
            req_valid = 1'b1; req_write = ~v.wr; req_addr = ~addr;
            req_mask = ~v.mask; req_wdata = ~v.wd;
         end
         if (poke && i == n - 1) req_valid = 1'b0;
         mem_dq_i = (i == int'(v.wt) + 1) ? v.rp : ~v.rp;
         strobe = (i >= 1) && (i <= int'(v.wt) + 1);
         e_bs = ~(v.mask & (v.mode ? 2'b11 : {strobe, strobe}));
         chk("R2", "cs_n", 32'(mem_cs_n), 32'd0);
         chk("R2", "addr", 32'(mem_addr), 32'(addr));
         chk(poke ? "R10" : "R2", "ready", 32'(req_ready), 32'd0);
         chk({tag, "/R9"}, $sformatf("bs_n cyc%0d", i), 32'(mem_bs_n), 32'(e_bs));
         chk(tag, $sformatf("rd_n cyc%0d", i), 32'(mem_rd_n),
             32'(!(strobe && !v.wr)));
         chk(tag, $sformatf("rdwr_n cyc%0d", i), 32'(mem_rdwr_n),
             32'(v.wr ? (v.mode ? !strobe : 1'b0) : 1'b1));
         chk("R7", "dq_oe", 32'(mem_dq_oe), 32'(v.wr));
         if (v.wr) chk("R7", "dq_o", 32'(mem_dq_o), 32'(v.wd));
         @(negedge clk);
      end
      chk("R2", "done", 32'(rsp_done), 32'd1);
      chk("R2", "cs_n end", 32'(mem_cs_n), 32'd1);
      chk("R2", "ready end", 32'(req_ready), 32'd1);
      chk("R7", "dq_oe end", 32'(mem_dq_oe), 32'd0);
      if (!v.wr) chk("R8", "rdata", 32'(rsp_rdata), 32'(v.rp));
      @(negedge clk);
      chk("R2", "done drop", 32'(rsp_done), 32'd0);
      chk(poke ? "R10" : "R1", "idle cs_n", 32'(mem_cs_n), 32'd1);
      cfg_bsel_mode = 1'b0; cfg_wait = '0; cfg_hold = '0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk("R1", "reset cs_n", 32'(mem_cs_n), 32'd1);
      chk("R1", "reset rd_n", 32'(mem_rd_n), 32'd1);
      chk("R1", "reset rdwr_n", 32'(mem_rdwr_n), 32'd1);
      chk("R1", "reset bs_n", 32'(mem_bs_n), 32'd3);
      chk("R1", "reset dq_oe", 32'(mem_dq_oe), 32'd0);
      chk("R1", "reset ready", 32'(req_ready), 32'd0 | 32'd1);
      chk("R1", "reset done", 32'(rsp_done), 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", "idle ready", 32'(req_ready), 32'd1);
      for (int k = 0; k < NVEC; k++)
         run_access(VEC[k], 21'(k * 4099 + 7), 1'b0, 1'b0);
      // R10: request held during a busy access
      run_access(VEC[2], 21'h1ABCD, 1'b1, 1'b0);
      run_access(VEC[1], 21'h00F0F, 1'b1, 1'b0);
      // R11: configuration changed mid-access
      run_access(VEC[6], 21'h15555, 1'b0, 1'b1);
      run_access(VEC[7], 21'h0AAAA, 1'b0, 1'b1);
      // R12: maximum hold on default-mode write and alternate-mode read
      run_access('{1'b0, 1'b1, 2'b01, 4'd1, 2'd3, 16'h3C3C, 16'h0}, 21'h3, 1'b0, 1'b0);
      run_access('{1'b1, 1'b0, 2'b10, 4'd0, 2'd3, 16'h0, 16'h6996}, 21'h4, 1'b0, 1'b0);
      // R3: longest wait in default-mode write
      run_access('{1'b0, 1'b1, 2'b11, 4'd15, 2'd0, 16'hFFFF, 16'h0}, 21'h1FFFFF, 1'b0, 1'b0);
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end
endmodule